// File: doc/BRIEF.md
# PDM Microphone Clock Generator and Bit Sampler

This block drives the bit clock of a pair of pulse-density-modulated microphones from a fast I/O clock. It also captures the single data line the two microphones share. One microphone drives the line during one phase of the bit clock and the other during the opposite phase. The block therefore samples the line once at each clock edge and delivers two bit streams, left and right. Each stream has a one-cycle strobe that marks a new bit. The decimation filters downstream consume these strobes and bits.

The divider is programmed as the division ratio minus two. The high phase of the bit clock lasts half the period rounded down, and the low phase takes the rest, so an odd ratio gives an uneven duty cycle. A new divider value is picked up only when a period starts, so no runt pulse can appear. A 4-bit skew value delays the outgoing clock by whole I/O cycles. An edge-swap bit exchanges which clock edge feeds the left stream, so that a single microphone wired as right can be processed as mono left. Each microphone has its own enable, and the clock stays low while both are off. A polarity bit inverts every captured bit.

Top module: `pdm_mic_frontend`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pdmClk, leftStb, rightStb, leftBit and rightBit are all 0.
- R2: While at least one microphone is enabled, pdmClk repeats with a period of divField+2 I/O clock cycles.
- R3: Within each period of N = divField+2 cycles, pdmClk is high for floor(N/2) cycles and low for the remaining N-floor(N/2) cycles.
- R4: A change of divField during a period leaves the current period's length and duty unchanged. The new value applies from the next period start.
- R5: pdmClk follows the internal clock waveform with a latency of 1+skewField I/O cycles, where skewField ranges from 0 to 15.
- R6: When enA and enB are both 0, the period counter stops and pdmClk goes low and stays low. When an enable returns, a fresh period starts with its high phase, and pdmClk first goes high two cycles after the enable is applied (skew 0).
- R7: With edgeSwap=0, a rising edge of pdmClk produces a left bit and a falling edge produces a right bit. The strobe is high for exactly the one cycle after the cycle in which the edge is visible on pdmClk. The bit is pdmData as sampled in the edge cycle, and it holds between strobes.
- R8: With edgeSwap=1, the falling edge produces the left bit and the rising edge produces the right bit.
- R9: leftStb can be high only if enA was 1 in the cycle before, and rightStb only if enB was 1 in the cycle before. A disabled side produces no strobe and keeps its bit.
- R10: With dataInvert=1, each captured bit is the complement of pdmData.
- R11: leftStb and rightStb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast I/O clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divField | input | DIV_W | Division ratio minus two |
| skewField | input | SKEW_W | Output clock delay in I/O cycles |
| edgeSwap | input | 1 | 1 = falling edge feeds left, rising edge feeds right |
| enA | input | 1 | Enable for the left (A) microphone |
| enB | input | 1 | Enable for the right (B) microphone |
| dataInvert | input | 1 | Invert captured bits |
| pdmData | input | 1 | Shared PDM data pin |
| pdmClk | output | 1 | Microphone bit clock |
| leftStb | output | 1 | One-cycle strobe for a new left bit |
| leftBit | output | 1 | Latest left bit |
| rightStb | output | 1 | One-cycle strobe for a new right bit |
| rightBit | output | 1 | Latest right bit |

## Verification
The bench builds the block with its default widths: an 8-bit divider field and a 4-bit skew field. With these widths the full skew range of sixteen delay settings is reachable. So are the short divide ratios of 2, 3 and 8, where the duty split and the period length can be counted cycle by cycle. A divider change in the middle of a period makes the boundary between old and new ratio observable within a few cycles. Enable toggling, edge swap and inversion are exercised at small ratios, where every edge falls within a short run.

// File: rtl/pdm_mic_pkg.sv
package pdm_mic_pkg;
  // Edge events of the outgoing bit clock, passed from control to datapath
  typedef struct packed {
    logic rise;
    logic fall;
  } pdmEdge_t;
endpackage

// File: rtl/pdm_skew_line.sv
module pdm_skew_line #(
  parameter int SKEW_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              din,
  input  logic [SKEW_W-1:0] sel,
  output logic              dout
);
  localparam int DEPTH = 1 << SKEW_W;

  logic [DEPTH-1:0] stage;

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[k] <= 1'b0;
          else       stage[k] <= din;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[k] <= 1'b0;
          else       stage[k] <= stage[k-1];
        end
      end
    end
  endgenerate

  assign dout = stage[sel];
endmodule

// File: rtl/pdm_clk_ctrl.sv
module pdm_clk_ctrl
  import pdm_mic_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int SKEW_W = 4,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divField,
  input  logic [SKEW_W-1:0] skewField,
  input  logic              runEn,
  output logic              pdmClk,
  output pdmEdge_t          edges,
  output logic              running,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  curN
);
  logic periodEnd;
  logic clkRaw;
  logic prevClk;

  assign periodEnd = (cnt == curN - 1'b1);

  // Period counter; the ratio is latched only at a period start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      curN    <= CNT_W'(2);
    end else if (!runEn) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running || periodEnd) begin
      running <= 1'b1;
      cnt     <= '0;
      curN    <= {1'b0, divField} + CNT_W'(2);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // High for the first floor(N/2) counts of each period
  assign clkRaw = running && (cnt < (curN >> 1));

  pdm_skew_line #(.SKEW_W(SKEW_W)) uSkew (
    .clk  (clk),
    .rstN (rstN),
    .din  (clkRaw),
    .sel  (skewField),
    .dout (pdmClk)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= pdmClk;
  end

  assign edges.rise = pdmClk & ~prevClk;
  assign edges.fall = ~pdmClk & prevClk;
endmodule

// File: rtl/pdm_sampler.sv
module pdm_sampler
  import pdm_mic_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  pdmEdge_t edges,
  input  logic     edgeSwap,
  input  logic     enA,
  input  logic     enB,
  input  logic     dataInvert,
  input  logic     pdmData,
  output logic     leftStb,
  output logic     leftBit,
  output logic     rightStb,
  output logic     rightBit
);
  logic leftEv;
  logic rightEv;
  logic dataIn;

  assign leftEv  = (edgeSwap ? edges.fall : edges.rise) & enA;
  assign rightEv = (edgeSwap ? edges.rise : edges.fall) & enB;
  assign dataIn  = pdmData ^ dataInvert;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftStb  <= 1'b0;
      leftBit  <= 1'b0;
      rightStb <= 1'b0;
      rightBit <= 1'b0;
    end else begin
      leftStb  <= leftEv;
      rightStb <= rightEv;
      if (leftEv)  leftBit  <= dataIn;
      if (rightEv) rightBit <= dataIn;
    end
  end
endmodule

// File: rtl/pdm_mic_frontend.sv
module pdm_mic_frontend
  import pdm_mic_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int SKEW_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divField,
  input  logic [SKEW_W-1:0] skewField,
  input  logic              edgeSwap,
  input  logic              enA,
  input  logic              enB,
  input  logic              dataInvert,
  input  logic              pdmData,
  output logic              pdmClk,
  output logic              leftStb,
  output logic              leftBit,
  output logic              rightStb,
  output logic              rightBit
);
  localparam int CNT_W = DIV_W + 1;

  pdmEdge_t         edges;
  logic             ctrlRunning;
  logic [CNT_W-1:0] ctrlCnt;
  logic [CNT_W-1:0] ctrlCurN;

  pdm_clk_ctrl #(.DIV_W(DIV_W), .SKEW_W(SKEW_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .divField  (divField),
    .skewField (skewField),
    .runEn     (enA | enB),
    .pdmClk    (pdmClk),
    .edges     (edges),
    .running   (ctrlRunning),
    .cnt       (ctrlCnt),
    .curN      (ctrlCurN)
  );

  pdm_sampler uSamp (
    .clk        (clk),
    .rstN       (rstN),
    .edges      (edges),
    .edgeSwap   (edgeSwap),
    .enA        (enA),
    .enB        (enB),
    .dataInvert (dataInvert),
    .pdmData    (pdmData),
    .leftStb    (leftStb),
    .leftBit    (leftBit),
    .rightStb   (rightStb),
    .rightBit   (rightBit)
  );
endmodule

// File: rtl/pdm_mic_frontend_chk.sv
module pdm_mic_frontend_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             enA,
  input logic             enB,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] curN,
  input logic             leftStb,
  input logic             leftBit,
  input logic             rightStb,
  input logic             rightBit
);
  // R6
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enA && !enB) |=> !running);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < curN);

  // R4
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> $stable(curN));

  // R9
  left_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftStb |-> $past(enA));

  // R9
  right_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rightStb |-> $past(enB));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(leftStb && rightStb));

  // R7
  left_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !leftStb |-> $stable(leftBit));

  // R7
  right_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rightStb |-> $stable(rightBit));
endmodule

bind pdm_mic_frontend pdm_mic_frontend_chk #(.CNT_W(CNT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .enA      (enA),
  .enB      (enB),
  .running  (ctrlRunning),
  .cnt      (ctrlCnt),
  .curN     (ctrlCurN),
  .leftStb  (leftStb),
  .leftBit  (leftBit),
  .rightStb (rightStb),
  .rightBit (rightBit)
);

// File: tb/pdm_mic_frontend_test.sv
module pdm_mic_frontend_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divField = 8'd0;
  logic [3:0] skewField = 4'd0;
  logic       edgeSwap = 1'b0;
  logic       enA = 1'b0;
  logic       enB = 1'b0;
  logic       dataInvert = 1'b0;
  logic       pdmData = 1'b0;
  logic       pdmClk, leftStb, leftBit, rightStb, rightBit;

  always #4 clk = ~clk;

  pdm_mic_frontend #(.DIV_W(8), .SKEW_W(4)) uut (
    .clk(clk), .rstN(rstN), .divField(divField), .skewField(skewField),
    .edgeSwap(edgeSwap), .enA(enA), .enB(enB), .dataInvert(dataInvert),
    .pdmData(pdmData), .pdmClk(pdmClk), .leftStb(leftStb), .leftBit(leftBit),
    .rightStb(rightStb), .rightBit(rightBit)
  );

  int nTests = 0;
  int nFail = 0;
  int cyc = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // Behavioural reference model
  int mRun = 0, mCnt = 0, mN = 2;
  bit mStage[16];
  bit mPrev = 0, mLs = 0, mLb = 0, mRs = 0, mRb = 0;

  always @(posedge clk) begin
    bit pc, rise, fall, aEv, bEv, d, raw;
    if (!rstN) begin
      mRun = 0; mCnt = 0; mN = 2; mPrev = 0;
      mLs = 0; mLb = 0; mRs = 0; mRb = 0;
      foreach (mStage[i]) mStage[i] = 0;
    end else begin
      pc = mStage[skewField];
      rise = pc && !mPrev;
      fall = !pc && mPrev;
      aEv = (edgeSwap ? fall : rise) && enA;
      bEv = (edgeSwap ? rise : fall) && enB;
      d = pdmData ^ dataInvert;
      mLs = aEv; if (aEv) mLb = d;
      mRs = bEv; if (bEv) mRb = d;
      raw = (mRun != 0) && (mCnt < mN / 2);
      for (int k = 15; k > 0; k--) mStage[k] = mStage[k-1];
      mStage[0] = raw;
      mPrev = pc;
      if (!(enA || enB)) begin
        mRun = 0; mCnt = 0;
      end else if (mRun == 0 || mCnt == mN - 1) begin
        mRun = 1; mCnt = 0; mN = int'(divField) + 2;
      end else begin
        mCnt++;
      end
    end
  end

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 60000) begin
      nFail++;
      $display("FAIL R2 watchdog: actual %0d cycles, expected fewer", cyc);
      finishRun();
    end
  end

  task automatic expectBit(string what, string rq, logic act, logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  task automatic expectInt(string what, string rq, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    expectBit("pdmClk", tag, pdmClk, mStage[skewField]);
    expectBit("leftStb", tag, leftStb, mLs);
    expectBit("leftBit", tag, leftBit, mLb);
    expectBit("rightStb", tag, rightStb, mRs);
    expectBit("rightBit", tag, rightBit, mRb);
    expectBit("strobe overlap", "R11", leftStb && rightStb, 1'b0);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pdmData = lfsr[0];
    end
  endtask

  // Count high and low run lengths of one full pdmClk period
  task automatic measure(int n);
    int hi = 0, lo = 0, guard = 0;
    while (pdmClk !== 1'b0 && guard < 1000) begin step(1); guard++; end
    while (pdmClk !== 1'b1 && guard < 2000) begin step(1); guard++; end
    while (pdmClk === 1'b1 && guard < 3000) begin hi++; step(1); guard++; end
    while (pdmClk === 1'b0 && guard < 4000) begin lo++; step(1); guard++; end
    expectInt("high phase", "R3", hi, n / 2);
    expectInt("low phase", "R3", lo, n - n / 2);
    expectInt("period", "R2", hi + lo, n);
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      expectBit("pdmClk in reset", "R1", pdmClk, 1'b0);
      expectBit("strobes in reset", "R1", leftStb | rightStb, 1'b0);
      expectBit("bits in reset", "R1", leftBit | rightBit, 1'b0);
    end
    rstN = 1'b1;
    step(1);
    tag = "R1";
    expectBit("pdmClk after reset", "R1", pdmClk, 1'b0);

    // R6: start-up from idle begins with a high phase
    tag = "R6";
    enA = 1'b1; enB = 1'b1;
    step(1);
    expectBit("pdmClk one cycle after enable", "R6", pdmClk, 1'b0);
    step(1);
    expectBit("pdmClk two cycles after enable", "R6", pdmClk, 1'b1);

    // R7: divide by 2, both microphones
    tag = "R7";
    step(40);
    measure(2);

    // R2 / R3: odd and even ratios
    tag = "R3";
    divField = 8'd1;
    step(10);
    measure(3);
    tag = "R2";
    divField = 8'd6;
    step(20);
    measure(8);

    // R4: ratio change in the middle of a period
    tag = "R4";
    step(3);
    divField = 8'd3;
    step(30);
    measure(5);
    divField = 8'd0;
    step(1);
    divField = 8'd4;
    step(30);
    measure(6);

    // R5: sweep the output delay
    tag = "R5";
    divField = 8'd2;
    for (int s = 0; s < 16; s++) begin
      skewField = 4'(s);
      step(14);
    end
    skewField = 4'd5;
    step(10);
    measure(4);
    skewField = 4'd0;
    step(10);

    // R8: swapped edges
    tag = "R8";
    edgeSwap = 1'b1;
    step(40);

    // R9: one side at a time
    tag = "R9";
    enB = 1'b0;
    step(30);
    enA = 1'b0; enB = 1'b1;
    step(30);
    edgeSwap = 1'b0;
    step(30);

    // R10: inverted data
    tag = "R10";
    enA = 1'b1; dataInvert = 1'b1;
    step(50);
    dataInvert = 1'b0;

    // R6: both disabled, clock stays low
    tag = "R6";
    skewField = 4'd3;
    enA = 1'b0; enB = 1'b0;
    step(10);
    for (int i = 0; i < 20; i++) begin
      step(1);
      expectBit("idle pdmClk", "R6", pdmClk, 1'b0);
      expectBit("idle strobes", "R6", leftStb | rightStb, 1'b0);
    end
    enA = 1'b1;
    step(40);
    measure(4);

    finishRun();
  end
endmodule